// File: doc/BRIEF.md
# Load/Store Address Region Router

This block takes the single load/store request of a 32-bit core and works out, in the same cycle, which device the address belongs to. The possible targets are a 1 KiB instruction RAM, a 1 KiB data RAM, the two control words of a heap allocator, and the banked heap storage. A small window of special word addresses does not reach any storage. A store or a load at one of those words fires a dedicated side-effect strobe for the console and debug logic instead.

Device selects and routine strobes are combinational, so a RAM sees its request in the cycle it is issued. The region picked for a load is registered beside the request. One cycle later the router returns the read data of that device, which suits RAMs with one cycle of read latency. A request that lands nowhere, or that uses the wrong direction at a routine word, selects nothing. It is reported on a one-cycle illegal flag that is aligned with the response.

Top module: `mmio_region_router`

## Requirements
- R1: A valid request with an address in 0x000..0x3FF sets `devSel` bit 0 (instruction RAM) and no other select or strobe, in the same cycle.
- R2: A valid request with an address in 0x400..0x7FF sets `devSel` bit 1 (data RAM) only, in the same cycle.
- R3: A valid load or store at exactly 0x830 or 0x834 sets `devSel` bit 2 (allocator control) only, in the same cycle.
- R4: A valid request at an address from 0xB700 up to 0xB700 + 128*64 - 1 (0xD6FF) sets `devSel` bit 3 (heap storage) only, in the same cycle.
- R5: A valid store at 0x800, 0x804, 0x808, 0x80C, 0x820, 0x824 or 0x828 raises `rtnStb` bit 0, 1, 2, 3, 6, 7 or 8 respectively, with no device select, and drives `rtnData` with the stored value in that cycle. `rtnData` is zero in every other cycle.
- R6: A valid load at 0x812 raises `rtnStb` bit 4, and one at 0x816 raises bit 5. The load result in the next cycle is `conRdata`.
- R7: Any other address is illegal. So is a load at a store-only routine word, a store at a load-only routine word, any other word in 0x800..0x8FF, and any address with bits above 15 set that falls outside the ranges above. An illegal request raises no select and no strobe, and it raises `illegalAccess` for exactly the next cycle.
- R8: Every valid load gives `loadValid` high in the next cycle. `loadData` then carries the read data of the device selected one cycle before, as presented on its input in that cycle, or zero for an illegal load. After a store or an idle cycle, `loadValid` is low and `loadData` is zero.
- R9: While `reqValid` is low, `devSel`, `rtnStb` and `rtnData` are zero, and in the next cycle `loadValid` and `illegalAccess` are low.
- R10: During reset `loadValid`, `illegalAccess` and `loadData` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present this cycle |
| reqWrite | input | 1 | 1 = store, 0 = load |
| reqAddr | input | 32 | Byte address of the request |
| reqWdata | input | 32 | Store data |
| imemRdata | input | 32 | Instruction RAM read data (one cycle after select) |
| dmemRdata | input | 32 | Data RAM read data |
| heapCtlRdata | input | 32 | Allocator control read data |
| heapRdata | input | 32 | Heap storage read data |
| conRdata | input | 32 | Console input value for the read routines |
| devSel | output | 4 | One-hot device select: 0 instr RAM, 1 data RAM, 2 allocator control, 3 heap |
| rtnStb | output | 9 | One-hot routine strobes, bit map in R5/R6 |
| rtnData | output | 32 | Stored value passed with a store routine strobe |
| loadValid | output | 1 | Load response valid |
| loadData | output | 32 | Load response data |
| illegalAccess | output | 1 | Previous request matched no legal target |

## Verification
The assertions take for granted that the core holds `reqValid` low through reset. They also assume each device returns its read data in the cycle after its select, so a registered select can be paired with the current read inputs. The stimulus keeps to this. Reset is released with the request idle. Every request is followed by an idle cycle in which the response is sampled. The device read inputs are distinct constants, so any wrong mux choice shows up as a different value. The address sweep covers every halfword in the low 4 KiB, every word up to 0xE000, and several addresses with high bits set, each as both a load and a store.

// File: rtl/mrr_pkg.sv
package mrr_pkg;

  // Device select positions
  localparam int NUM_DEV  = 4;
  localparam int DEV_IMEM = 0;
  localparam int DEV_DMEM = 1;
  localparam int DEV_HCTL = 2;
  localparam int DEV_HEAP = 3;

  // Routine words, offsets relative to the routine window base.
  // Strobe bit i belongs to offset RTN_OFF[i].
  localparam int NUM_RTN = 9;
  localparam logic [7:0] RTN_OFF [NUM_RTN] = '{
    8'h00, 8'h04, 8'h08, 8'h0C, 8'h12, 8'h16, 8'h20, 8'h24, 8'h28
  };
  // 1 = store-triggered word, 0 = load-triggered word
  localparam logic [NUM_RTN-1:0] RTN_IS_STORE = 9'b111001111;

  // Allocator control words, same base as the routine window
  localparam int NUM_HCTL = 2;
  localparam logic [7:0] HCTL_OFF [NUM_HCTL] = '{8'h30, 8'h34};

  // Control-to-datapath strobe bundle
  typedef struct packed {
    logic [NUM_DEV-1:0] sel;
    logic [NUM_RTN-1:0] rtn;
    logic               conRead;
    logic               rtnWrite;
    logic               load;
    logic               illegal;
  } decodeStrobes_t;

endpackage

// File: rtl/mrr_decode.sv
module mrr_decode
  import mrr_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int IMEM_BYTES = 1024,
  parameter int DMEM_BYTES = 1024,
  parameter int RTN_BASE   = 'h800,
  parameter int HEAP_BASE  = 'hB700,
  parameter int HEAP_BANKS = 128,
  parameter int BANK_BYTES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  output decodeStrobes_t    ds
);

  localparam logic [ADDR_W-1:0] IMEM_END_A = ADDR_W'(IMEM_BYTES);
  localparam logic [ADDR_W-1:0] DMEM_END_A = ADDR_W'(IMEM_BYTES + DMEM_BYTES);
  localparam logic [ADDR_W-1:0] RTN_BASE_A = ADDR_W'(RTN_BASE);
  localparam logic [ADDR_W-1:0] HEAP_LO_A  = ADDR_W'(HEAP_BASE);
  localparam logic [ADDR_W-1:0] HEAP_HI_A  = ADDR_W'(HEAP_BASE + HEAP_BANKS * BANK_BYTES);

  // Full-width offset into the routine window: an exact compare against the
  // whole value keeps aliases with upper bits set from matching.
  logic [ADDR_W-1:0]   rtnRel;
  logic [NUM_RTN-1:0]  rtnHit;
  logic [NUM_RTN-1:0]  rtnStb;
  logic [NUM_HCTL-1:0] hctlHit;
  logic [NUM_DEV-1:0]  sel;

  assign rtnRel = reqAddr - RTN_BASE_A;

  for (genvar i = 0; i < NUM_RTN; i++) begin : g_rtn
    assign rtnHit[i] = reqValid && (rtnRel == ADDR_W'(RTN_OFF[i]));
    assign rtnStb[i] = rtnHit[i] && (reqWrite == RTN_IS_STORE[i]);
  end

  for (genvar h = 0; h < NUM_HCTL; h++) begin : g_hctl
    assign hctlHit[h] = reqValid && (rtnRel == ADDR_W'(HCTL_OFF[h]));
  end

  always_comb begin
    sel           = '0;
    sel[DEV_IMEM] = reqValid && (reqAddr < IMEM_END_A);
    sel[DEV_DMEM] = reqValid && (reqAddr >= IMEM_END_A) && (reqAddr < DMEM_END_A);
    sel[DEV_HCTL] = |hctlHit;
    sel[DEV_HEAP] = reqValid && (reqAddr >= HEAP_LO_A) && (reqAddr < HEAP_HI_A);
  end

  always_comb begin
    ds          = '0;
    ds.sel      = sel;
    ds.rtn      = rtnStb;
    ds.conRead  = |(rtnStb & ~RTN_IS_STORE);
    ds.rtnWrite = |(rtnStb & RTN_IS_STORE);
    ds.load     = reqValid && !reqWrite;
    ds.illegal  = reqValid && !(|sel) && !(|rtnStb);
  end

  // R7
  target_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ds.sel, ds.rtn}));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |-> (ds.sel == '0 && ds.rtn == '0 && !ds.illegal));

  // R5
  store_word_dir_chk: assert property (@(posedge clk) disable iff (!rstN)
    ds.rtnWrite |-> (reqWrite && !ds.load));

  // R6
  load_word_dir_chk: assert property (@(posedge clk) disable iff (!rstN)
    ds.conRead |-> (ds.load && ds.sel == '0));

endmodule

// File: rtl/mrr_datapath.sv
module mrr_datapath
  import mrr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  decodeStrobes_t    ds,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] devRdata [NUM_DEV],
  input  logic [DATA_W-1:0] conRdata,
  output logic [DATA_W-1:0] rtnData,
  output logic              loadValid,
  output logic [DATA_W-1:0] loadData,
  output logic              illegalAccess
);

  logic [NUM_DEV-1:0] selQ;
  logic               conQ;
  logic               loadQ;
  logic               illQ;
  logic [DATA_W-1:0]  muxAcc;

  // Only loads keep their select, so a store leaves no stale response
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selQ  <= '0;
      conQ  <= 1'b0;
      loadQ <= 1'b0;
      illQ  <= 1'b0;
    end else begin
      selQ  <= ds.load ? ds.sel : '0;
      conQ  <= ds.conRead;
      loadQ <= ds.load;
      illQ  <= ds.illegal;
    end
  end

  always_comb begin
    muxAcc = '0;
    for (int d = 0; d < NUM_DEV; d++) begin
      if (selQ[d]) muxAcc = muxAcc | devRdata[d];
    end
    if (conQ) muxAcc = muxAcc | conRdata;
  end

  assign loadData      = loadQ ? muxAcc : '0;
  assign loadValid     = loadQ;
  assign illegalAccess = illQ;
  assign rtnData       = ds.rtnWrite ? reqWdata : '0;

  // R8
  load_resp_origin_chk: assert property (@(posedge clk) disable iff (!rstN)
    loadValid |-> $past(ds.load));

  // R7
  illegal_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    illegalAccess |-> $past(ds.illegal));

  // R8
  illegal_load_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (loadValid && illegalAccess) |-> (loadData == '0));

  // R8
  no_resp_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !loadValid |-> (loadData == '0));

endmodule

// File: rtl/mmio_region_router.sv
module mmio_region_router
  import mrr_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int IMEM_BYTES = 1024,
  parameter int DMEM_BYTES = 1024,
  parameter int RTN_BASE   = 'h800,
  parameter int HEAP_BASE  = 'hB700,
  parameter int HEAP_BANKS = 128,
  parameter int BANK_BYTES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] imemRdata,
  input  logic [DATA_W-1:0] dmemRdata,
  input  logic [DATA_W-1:0] heapCtlRdata,
  input  logic [DATA_W-1:0] heapRdata,
  input  logic [DATA_W-1:0] conRdata,
  output logic [3:0]        devSel,
  output logic [8:0]        rtnStb,
  output logic [DATA_W-1:0] rtnData,
  output logic              loadValid,
  output logic [DATA_W-1:0] loadData,
  output logic              illegalAccess
);

  decodeStrobes_t    ds;
  logic [DATA_W-1:0] devRdata [NUM_DEV];

  assign devRdata[DEV_IMEM] = imemRdata;
  assign devRdata[DEV_DMEM] = dmemRdata;
  assign devRdata[DEV_HCTL] = heapCtlRdata;
  assign devRdata[DEV_HEAP] = heapRdata;

  mrr_decode #(
    .ADDR_W    (ADDR_W),
    .IMEM_BYTES(IMEM_BYTES),
    .DMEM_BYTES(DMEM_BYTES),
    .RTN_BASE  (RTN_BASE),
    .HEAP_BASE (HEAP_BASE),
    .HEAP_BANKS(HEAP_BANKS),
    .BANK_BYTES(BANK_BYTES)
  ) u_decode (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .reqAddr (reqAddr),
    .ds      (ds)
  );

  mrr_datapath #(
    .DATA_W(DATA_W)
  ) u_datapath (
    .clk          (clk),
    .rstN         (rstN),
    .ds           (ds),
    .reqWdata     (reqWdata),
    .devRdata     (devRdata),
    .conRdata     (conRdata),
    .rtnData      (rtnData),
    .loadValid    (loadValid),
    .loadData     (loadData),
    .illegalAccess(illegalAccess)
  );

  assign devSel = ds.sel;
  assign rtnStb = ds.rtn;

endmodule

// File: tb/mmio_region_router_test.sv
`timescale 1ns/1ps
module mmio_region_router_test;

  localparam logic [31:0] D_IMEM = 32'h1A1A_0001;
  localparam logic [31:0] D_DMEM = 32'h2B2B_0002;
  localparam logic [31:0] D_HCTL = 32'h3C3C_0004;
  localparam logic [31:0] D_HEAP = 32'h4D4D_0008;
  localparam logic [31:0] D_CON  = 32'h5E5E_0010;
  localparam logic [8:0]  STORE_WORDS = 9'b111001111;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic [3:0]  devSel;
  logic [8:0]  rtnStb;
  logic [31:0] rtnData;
  logic        loadValid;
  logic [31:0] loadData;
  logic        illegalAccess;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  mmio_region_router uut (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .imemRdata(D_IMEM), .dmemRdata(D_DMEM), .heapCtlRdata(D_HCTL),
    .heapRdata(D_HEAP), .conRdata(D_CON),
    .devSel(devSel), .rtnStb(rtnStb), .rtnData(rtnData),
    .loadValid(loadValid), .loadData(loadData), .illegalAccess(illegalAccess)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s addr=%h actual=%h expected=%h", tag, what, reqAddr, act, exp);
    end
  endtask

  // Expected target, computed from the address map in the requirements
  task automatic model(input bit wr, input logic [31:0] a,
                       output logic [3:0] es, output logic [8:0] er,
                       output bit ill, output string tag);
    es = '0; er = '0; tag = "R7";
    if (a < 32'h400) begin es = 4'b0001; tag = "R1"; end
    else if (a < 32'h800) begin es = 4'b0010; tag = "R2"; end
    else if (a < 32'h900) begin
      case (a - 32'h800)
        32'h30, 32'h34: begin es = 4'b0100; tag = "R3"; end
        32'h00: er[0] = wr;
        32'h04: er[1] = wr;
        32'h08: er[2] = wr;
        32'h0C: er[3] = wr;
        32'h12: er[4] = !wr;
        32'h16: er[5] = !wr;
        32'h20: er[6] = wr;
        32'h24: er[7] = wr;
        32'h28: er[8] = wr;
        default: ;
      endcase
      if (er != '0) tag = wr ? "R5" : "R6";
    end
    else if (a >= 32'hB700 && a < 32'hB700 + 128 * 64) begin es = 4'b1000; tag = "R4"; end
    ill = (es == '0) && (er == '0);
  endtask

  task automatic doReq(input bit wr, input logic [31:0] a);
    logic [3:0]  es;
    logic [8:0]  er;
    bit          ill;
    string       tag;
    logic [31:0] wd;
    logic [31:0] expLoad;
    @(negedge clk);
    // response of the preceding idle cycle
    chk("R9", "idle loadValid", 32'(loadValid), 32'h0);
    chk("R9", "idle illegalAccess", 32'(illegalAccess), 32'h0);
    wd = a ^ 32'h5A5A_C3C3;
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = wd;
    #1;
    model(wr, a, es, er, ill, tag);
    chk(tag, "devSel", 32'(devSel), 32'(es));
    chk(tag, "rtnStb", 32'(rtnStb), 32'(er));
    chk((er & STORE_WORDS) != '0 ? "R5" : tag, "rtnData", rtnData,
        ((er & STORE_WORDS) != '0) ? wd : 32'h0);
    @(negedge clk);
    reqValid = 1'b0;
    #1;
    if (ill || wr) expLoad = '0;
    else if (er != '0) expLoad = D_CON;
    else if (es[0]) expLoad = D_IMEM;
    else if (es[1]) expLoad = D_DMEM;
    else if (es[2]) expLoad = D_HCTL;
    else expLoad = D_HEAP;
    chk("R8", "loadValid", 32'(loadValid), 32'(!wr));
    chk((er != '0 && !wr) ? "R6" : "R8", "loadData", loadData, expLoad);
    chk("R7", "illegalAccess", 32'(illegalAccess), 32'(ill));
    chk("R9", "idle devSel", 32'(devSel), 32'h0);
    chk("R9", "idle rtnStb", 32'(rtnStb), 32'h0);
    chk("R9", "idle rtnData", rtnData, 32'h0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired before the sweep finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    repeat (4) @(negedge clk);
    // R10 reset state
    chk("R10", "reset loadValid", 32'(loadValid), 32'h0);
    chk("R10", "reset illegalAccess", 32'(illegalAccess), 32'h0);
    chk("R10", "reset loadData", loadData, 32'h0);
    chk("R9", "reset devSel", 32'(devSel), 32'h0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // Low window: every halfword, both directions (R1 R2 R3 R5 R6 R7)
    for (int a = 0; a < 'h1000; a += 2) begin
      doReq(1'b0, 32'(a));
      doReq(1'b1, 32'(a));
    end
    // Gap, heap and above (R4 R7), word steps
    for (int a = 'h1000; a <= 'hE000; a += 4) begin
      doReq(1'b0, 32'(a));
      doReq(1'b1, 32'(a));
    end
    // Aliases with high address bits set (R7)
    doReq(1'b1, 32'h0001_0800);
    doReq(1'b0, 32'h0001_0812);
    doReq(1'b0, 32'h0001_0000);
    doReq(1'b1, 32'h8000_0004);
    doReq(1'b0, 32'h0001_B700);
    doReq(1'b1, 32'hFFFF_FFFC);
    doReq(1'b0, 32'hFFFF_F830);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule